// File: doc/BRIEF.md
# Condition Flag Keeper and Branch Target Resolver

This block holds the three condition flags of a 16-bit processor: negative, zero and positive. It also decides where control goes next for the two control-transfer encodings it knows. When the datapath writes a register and raises the set-flags strobe, the block classifies the written 16-bit value. On the next rising clock edge it stores exactly one of the three flags.

In the same cycle the block receives the fetched instruction word, the program counter that already points at the next instruction, and the contents of the base register named by the instruction. From these it produces a taken indication and the next program counter. Both outputs are combinational from the current inputs and the stored flags. A conditional branch compares its three-bit mask against the stored flags. A mask of all ones always branches and a mask of all zeros never does. The register jump always transfers to the base register contents. Every other opcode falls through to the incremented counter. The register file, memory and instruction fetch stay outside the block. The block reports which base register it needs, and the surrounding datapath supplies that register's value.

Top module: `rr_branch_unit`

## Requirements
- R1: While reset is active and after it is released, the flag output `cc_flags` (bit 2 = negative, bit 1 = zero, bit 0 = positive) reads 3'b010 until the first strobed update.
- R2: When `set_cc` is high at a rising edge, from that edge on the flags hold 3'b100 if `wr_result[15]` is 1, 3'b010 if `wr_result` is all zeros, and 3'b001 otherwise.
- R3: When `set_cc` is low at a rising edge, the flags keep their previous value whatever `wr_result` holds.
- R4: Exactly one of the three flags is set at every clock edge out of reset.
- R5: For opcode `inst_word[15:12]` = 4'b0000, `br_taken` is 1 exactly when the mask `inst_word[11:9]` (bit 11 = negative, bit 10 = zero, bit 9 = positive) shares a set bit with the stored flags. Mask 3'b000 is never taken and mask 3'b111 is always taken.
- R6: A taken conditional branch drives `next_pc` to `pc_inc` plus the 9-bit two's complement offset `inst_word[8:0]` sign-extended to 16 bits, wrapping modulo 2^16.
- R7: A not-taken conditional branch, and any opcode other than 4'b0000 and 4'b1100, gives `br_taken` = 0 and `next_pc` = `pc_inc`.
- R8: For opcode 4'b1100, `br_taken` is 1, `next_pc` equals `base_val`, and `base_idx` equals `inst_word[8:6]`. `base_idx` always shows `inst_word[8:6]`.
- R9: A conditional branch presented in the same cycle as a `set_cc` strobe resolves against the flags stored before that edge, not the ones being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_cc | input | 1 | Strobe: classify `wr_result` into the flags at this edge |
| wr_result | input | 16 | Value being written to a register |
| inst_word | input | 16 | Fetched instruction word |
| pc_inc | input | 16 | Program counter already pointing at the next instruction |
| base_val | input | 16 | Contents of the register named by `base_idx` |
| base_idx | output | 3 | Base register index taken from `inst_word[8:6]` |
| br_taken | output | 1 | Control transfer taken this cycle |
| next_pc | output | 16 | Address of the next instruction |
| cc_flags | output | 3 | Stored negative/zero/positive flags |

## Verification
The conditional branch is driven with every mask value against each of the three flag states. This separates an OR-style match from an AND-style or an exact-equal match. Offsets at both ends of the 9-bit range and program counters near 16'h0000 and 16'hFFFF expose a missing sign extension or a wrong wrap. Strobed writes of negative, zero, small positive and 16'h7FFF results are interleaved with unstrobed writes and same-cycle branches. These show whether the flag source, the update gate and the branch's view of the old flags are correct. A long pseudo-random phase mixes all opcodes, with the jump base value varied, and compares every cycle against a behavioural model.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;

    localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    typedef enum logic [3:0] {
        OPC_BR  = 4'b0000,
        OPC_JMP = 4'b1100
    } ctl_op_e;

endpackage

// File: rtl/cc_classify.sv
module cc_classify
    import rr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    output cc_t               cls
);

    localparam int SIGN_BIT = DATA_W - 1;

    always_comb begin
        cls.n = value[SIGN_BIT];
        cls.z = (value == '0);
        cls.p = ~value[SIGN_BIT] & (value != '0);
    end

endmodule

// File: rtl/cc_state.sv
module cc_state
    import rr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_cc,
    input  cc_t  cls_in,
    output cc_t  cc_q
);

    typedef struct packed {
        cc_t cc;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        if (set_cc) begin
            st_d.cc = cls_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cc: CC_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    assign cc_q = st_q.cc;

    AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_q) == 1); // R4

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !set_cc |=> $stable(cc_q)); // R3

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        set_cc |=> (cc_q == $past(cls_in))); // R2

endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import rr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int OP_W     = 4,
    parameter int OFF_W    = 9,
    parameter int RIDX_W   = 3,
    parameter int BASE_LSB = 6
) (
    input  logic [DATA_W-1:0] inst,
    input  logic [DATA_W-1:0] pc_inc,
    input  logic [DATA_W-1:0] base_val,
    input  cc_t               cc,
    output logic              taken,
    output logic [DATA_W-1:0] next_pc,
    output logic [RIDX_W-1:0] base_idx
);

    localparam int OP_LSB   = DATA_W - OP_W;
    localparam int MASK_LSB = OFF_W;
    localparam int EXT_W    = DATA_W - OFF_W;

    typedef struct packed {
        logic              taken;
        logic [DATA_W-1:0] pc;
    } res_t;

    logic [OP_W-1:0]   opcode;
    cc_t               mask;
    logic [DATA_W-1:0] offset_ext;
    logic [DATA_W-1:0] br_target;
    logic              cond_hit;
    res_t              res_d;

    assign opcode   = inst[DATA_W-1:OP_LSB];
    assign mask     = cc_t'(inst[MASK_LSB+2:MASK_LSB]);
    assign base_idx = inst[BASE_LSB+RIDX_W-1:BASE_LSB];

    generate
        if (EXT_W > 0) begin : g_sext
            assign offset_ext = {{EXT_W{inst[OFF_W-1]}}, inst[OFF_W-1:0]};
        end else begin : g_nosext
            assign offset_ext = inst[DATA_W-1:0];
        end
    endgenerate

    assign br_target = pc_inc + offset_ext;
    assign cond_hit  = |(mask & cc);

    always_comb begin
        res_d.taken = 1'b0;
        res_d.pc    = pc_inc;
        case (opcode)
            OPC_BR: begin
                if (cond_hit) begin
                    res_d.taken = 1'b1;
                    res_d.pc    = br_target;
                end
            end
            OPC_JMP: begin
                res_d.taken = 1'b1;
                res_d.pc    = base_val;
            end
            default: begin
                res_d.taken = 1'b0;
                res_d.pc    = pc_inc;
            end
        endcase
    end

    assign taken   = res_d.taken;
    assign next_pc = res_d.pc;

endmodule

// File: rtl/rr_branch_unit.sv
module rr_branch_unit
    import rr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int OFF_W  = 9,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_cc,
    input  logic [DATA_W-1:0] wr_result,
    input  logic [DATA_W-1:0] inst_word,
    input  logic [DATA_W-1:0] pc_inc,
    input  logic [DATA_W-1:0] base_val,
    output logic [RIDX_W-1:0] base_idx,
    output logic              br_taken,
    output logic [DATA_W-1:0] next_pc,
    output logic [2:0]        cc_flags
);

    localparam int OP_LSB   = DATA_W - OP_W;
    localparam int MASK_LSB = OFF_W;

    cc_t cls_w;
    cc_t cc_w;

    cc_classify #(.DATA_W(DATA_W)) i_classify (
        .value (wr_result),
        .cls   (cls_w)
    );

    cc_state i_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_cc (set_cc),
        .cls_in (cls_w),
        .cc_q   (cc_w)
    );

    br_resolve #(
        .DATA_W (DATA_W),
        .OP_W   (OP_W),
        .OFF_W  (OFF_W),
        .RIDX_W (RIDX_W)
    ) i_resolve (
        .inst     (inst_word),
        .pc_inc   (pc_inc),
        .base_val (base_val),
        .cc       (cc_w),
        .taken    (br_taken),
        .next_pc  (next_pc),
        .base_idx (base_idx)
    );

    assign cc_flags = cc_w;

    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_word[DATA_W-1:OP_LSB] == OPC_JMP) |-> (br_taken && next_pc == base_val)); // R8

    AST_MASK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_word[DATA_W-1:OP_LSB] == OPC_BR && inst_word[MASK_LSB+2:MASK_LSB] == 3'b000)
        |-> !br_taken); // R5

    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_word[DATA_W-1:OP_LSB] == OPC_BR && inst_word[MASK_LSB+2:MASK_LSB] == 3'b111)
        |-> br_taken); // R5

    AST_FALLTHRU_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> (next_pc == pc_inc)); // R7

endmodule

// File: tb/test_rr_branch_unit.sv
module test_rr_branch_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_cc = 1'b0;
    logic [15:0] wr_result = '0;
    logic [15:0] inst_word = 16'h5000;
    logic [15:0] pc_inc = 16'h3001;
    logic [15:0] base_val = '0;
    logic [2:0]  base_idx;
    logic        br_taken;
    logic [15:0] next_pc;
    logic [2:0]  cc_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [2:0] m_cc = 3'b010;

    always #(CLK_PERIOD/2) clk = ~clk;

    rr_branch_unit i_rr_branch_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_cc    (set_cc),
        .wr_result (wr_result),
        .inst_word (inst_word),
        .pc_inc    (pc_inc),
        .base_val  (base_val),
        .base_idx  (base_idx),
        .br_taken  (br_taken),
        .next_pc   (next_pc),
        .cc_flags  (cc_flags)
    );

    function automatic logic [2:0] classify(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, check outputs, then advance the model past the rising edge.
    task automatic step(input logic [15:0] iw, input logic [15:0] pc, input logic [15:0] bv,
                        input logic sc, input logic [15:0] res);
        int off;
        int exp_pc;
        logic exp_tk;
        @(negedge clk);
        inst_word = iw; pc_inc = pc; base_val = bv; set_cc = sc; wr_result = res;
        #1;
        exp_tk = 1'b0;
        exp_pc = pc;
        if (iw[15:12] == 4'b0000) begin
            off = int'(iw[8:0]);
            if (off >= 256) off -= 512;
            if ((iw[11:9] & m_cc) != 3'b000) begin
                exp_tk = 1'b1;
                exp_pc = (int'(pc) + off) & 16'hFFFF;
            end
            cmp("R5/R9 taken", br_taken, exp_tk);
            cmp(exp_tk ? "R6 target" : "R7 fallthrough", next_pc, exp_pc);
        end else if (iw[15:12] == 4'b1100) begin
            cmp("R8 taken", br_taken, 1);
            cmp("R8 target", next_pc, bv);
        end else begin
            cmp("R7 taken", br_taken, 0);
            cmp("R7 next_pc", next_pc, pc);
        end
        cmp("R8 base_idx", base_idx, iw[8:6]);
        cmp("R2/R3 flags", cc_flags, m_cc);
        cmp("R4 one flag", $countones(cc_flags), 1);
        @(posedge clk);
        if (sc) m_cc = classify(res);
    endtask

    function automatic logic [15:0] br(input logic [2:0] m, input logic [8:0] off);
        return {4'b0000, m, off};
    endfunction

    initial begin
        #(CLK_PERIOD * 2 + 2);
        cmp("R1 reset flags", cc_flags, 3'b010);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: zero flag after reset
        step(16'h1234, 16'h3001, 16'h0, 1'b0, 16'h8000);
        // R5: each mask against Z
        for (int m = 0; m < 8; m++) step(br(3'(m), 9'h005), 16'h3005, 16'h0, 1'b0, 16'h0);
        // R2: negative result
        step(16'h5000, 16'h3006, 16'h0, 1'b1, 16'hFFFF);
        for (int m = 0; m < 8; m++) step(br(3'(m), 9'h1FA), 16'h300A, 16'h0, 1'b0, 16'h0);
        // R2: positive boundary
        step(16'h5000, 16'h3006, 16'h0, 1'b1, 16'h7FFF);
        for (int m = 0; m < 8; m++) step(br(3'(m), 9'h0FF), 16'hFFF0, 16'h0, 1'b0, 16'h0);
        // R6: offset extremes and wrap
        step(br(3'b111, 9'h100), 16'h0010, 16'h0, 1'b0, 16'h0);
        step(br(3'b111, 9'h0FF), 16'hFFFF, 16'h0, 1'b0, 16'h0);
        // R3: unstrobed writes leave flags alone
        step(16'h1000, 16'h4000, 16'h0, 1'b0, 16'h8001);
        step(16'h1000, 16'h4000, 16'h0, 1'b0, 16'h0000);
        // R9: branch sees old flags (P) while zero is written
        step(br(3'b010, 9'h004), 16'h4000, 16'h0, 1'b1, 16'h0000);
        step(br(3'b010, 9'h004), 16'h4000, 16'h0, 1'b1, 16'h0001);
        step(br(3'b001, 9'h004), 16'h4000, 16'h0, 1'b0, 16'h0);
        // R8: jumps with various bases
        step({4'b1100, 3'b000, 3'b111, 6'h0}, 16'h3011, 16'hABCD, 1'b0, 16'h0);
        step({4'b1100, 3'b000, 3'b010, 6'h0}, 16'h3011, 16'h0000, 1'b1, 16'h8000);
        // R7: other opcodes with mask-looking bits
        step({4'b1111, 12'hE25}, 16'h300B, 16'h1111, 1'b0, 16'h0);
        step({4'b0100, 12'hFFF}, 16'h300B, 16'h1111, 1'b0, 16'h0);
        // pseudo-random mix
        for (int i = 0; i < 600; i++) begin
            logic [15:0] iw;
            iw = 16'($urandom);
            case ($urandom % 4)
                0: iw[15:12] = 4'b0000;
                1: iw[15:12] = 4'b1100;
                default: ;
            endcase
            step(iw, 16'($urandom), 16'($urandom), 1'($urandom),
                 ($urandom % 4 == 0) ? 16'h0 : 16'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule